// File: doc/BRIEF.md
# Configuration Word Stream Loader

This block turns a stream of 16-bit configuration words, fetched one at a time from an external serial EEPROM reader, into single-cycle register write strobes. A header supplies a three-bit zone-enable vector. The loader walks the enabled zones in a fixed order: local register overrides, identification bytes, then per-function configuration space overrides. Each word carries its own continuation bit. When a word has that bit clear, the loader moves to the next enabled zone, or finishes if no later zone is enabled.

Every write strobe carries four things: a space select (local registers or configuration space), a per-function target mask, a byte offset and a data byte. Identification bytes are broadcast to both functions. In the per-function zone, function-header words retarget the words that follow them. Reserved codes raise a sticky error flag. The words that carry them are skipped, and the stream keeps moving.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset, word_req, wr_en, done and err are all 0, and the loader waits for hdr_vld.
- R2: On hdr_vld, zone_en is latched. Bit 0 enables the local zone, bit 1 the identification zone and bit 2 the per-function zone. Zones are visited in that order. With no zone enabled, done is 1 in the cycle after hdr_vld. Otherwise word_req is 1 in that cycle.
- R3: A word is accepted on a clock edge where word_req and word_vld are both 1. Its fields are: bit 15 is the continuation flag, bits 14:8 the byte offset, bits 7:0 the data. Any resulting write has wr_en high for exactly the one cycle after acceptance.
- R4: In the local zone, a write has wr_cfg=0 and wr_fn=00, and is issued only if LOCAL_WMASK[offset] is 1. Other offsets are dropped without raising err.
- R5: A word with bit 15 = 0 ends its zone. Disabled zones are skipped, and exactly the words of the enabled zones are requested.
- R6: In the identification zone, offsets 0..3 produce one write with wr_cfg=1 and wr_fn=11. The offsets map to configuration offsets 0x00, 0x01, 0x2C and 0x2D.
- R7: An identification offset of 4 or more sets err and produces no write.
- R8: In the per-function zone, a header word with bit 15 = 1 selects a function from bits 2:0. Code 0 gives wr_fn=01 and code 1 gives wr_fn=10. The words after the header write only that function, with wr_cfg=1. When one of them has bit 15 = 0, the next word is read as a header.
- R9: A header with function code 2 or higher sets err. The words under that header are consumed and produce no write.
- R10: A per-function word aimed at offset 0x00, 0x01, 0x2C or 0x2D produces no write and sets err.
- R11: A header word with bit 15 = 0 ends the per-function zone. Once the last enabled zone has ended, done stays 1 and word_req stays 0 until reset, and hdr_vld is ignored.
- R12: err, once set, stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_vld | input | 1 | Header valid pulse, starts the walk |
| zone_en | input | 3 | Zone enables: local, identification, per-function |
| word_req | output | 1 | Loader wants the next word |
| word_vld | input | 1 | Reader presents a word |
| word_data | input | 16 | Configuration word |
| wr_en | output | 1 | Write strobe |
| wr_cfg | output | 1 | 0 = local registers, 1 = configuration space |
| wr_fn | output | 2 | Per-function target mask |
| wr_ofs | output | 7 | Byte offset |
| wr_data | output | 8 | Data byte |
| done | output | 1 | Walk finished (sticky) |
| err | output | 1 | Reserved code seen (sticky) |

## Verification
A wrong zone or function state shows up within one or two accepted words. Writes appear with the wrong space, mask or offset, or expected writes go missing. It also shows as a wrong count of consumed words, which pulls the stream out of step: later words are then decoded as headers or as payload. Lost continuation tracking shows up as done rising too early or never. The bench sweeps every zone-enable combination, with and without gaps in word_vld. It compares the full write log, the number of words consumed, err and done against an arithmetic walk of the same stream.

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader #(
  parameter int OFS_W  = 7,
  parameter int DATA_W = 8,
  parameter int FN_W   = 3,
  parameter int NFN    = 2,
  parameter logic [(1<<OFS_W)-1:0] LOCAL_WMASK = 128'h0000_0000_0000_0000_0000_00FF_F0F0_FFF7,
  parameter logic [OFS_W-1:0] SVID_OFS = 7'h2C
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hdr_vld,
  input  logic [2:0]                zone_en,
  output logic                      word_req,
  input  logic                      word_vld,
  input  logic [OFS_W+DATA_W:0]     word_data,
  output logic                      wr_en,
  output logic                      wr_cfg,
  output logic [NFN-1:0]            wr_fn,
  output logic [OFS_W-1:0]          wr_ofs,
  output logic [DATA_W-1:0]         wr_data,
  output logic                      done,
  output logic                      err
);
  localparam int WORD_W = OFS_W + DATA_W + 1;
  localparam logic [OFS_W-1:0] SVID_HI = SVID_OFS + OFS_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_LOCAL, S_ID, S_FHDR, S_FCFG, S_DONE} st_t;

  st_t              st;
  logic [2:0]       en_q;
  logic [FN_W-1:0]  fn_q;
  logic             fn_bad;

  logic              take, w_cont, id_ok, hdr_bad, ofs_vid;
  logic [OFS_W-1:0]  w_ofs, id_ofs;
  logic [DATA_W-1:0] w_dat;
  logic [FN_W-1:0]   w_fn;

  function automatic st_t first_zone(input logic [2:0] en);
    if (en[0])      return S_LOCAL;
    else if (en[1]) return S_ID;
    else if (en[2]) return S_FHDR;
    else            return S_DONE;
  endfunction

  function automatic logic is_vid(input logic [OFS_W-1:0] o);
    return (o == '0) || (o == OFS_W'(1)) || (o == SVID_OFS) || (o == SVID_HI);
  endfunction

  assign take     = word_req & word_vld;
  assign w_cont   = word_data[WORD_W-1];
  assign w_ofs    = word_data[WORD_W-2 -: OFS_W];
  assign w_dat    = word_data[DATA_W-1:0];
  assign w_fn     = word_data[FN_W-1:0];
  assign id_ok    = (w_ofs < OFS_W'(4));
  assign id_ofs   = w_ofs[1] ? (w_ofs[0] ? SVID_HI : SVID_OFS) : OFS_W'(w_ofs[0]);
  assign hdr_bad  = (w_fn >= FN_W'(NFN));
  assign ofs_vid  = is_vid(w_ofs);
  assign word_req = (st == S_LOCAL) || (st == S_ID) || (st == S_FHDR) || (st == S_FCFG);
  assign done     = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      en_q    <= '0;
      fn_q    <= '0;
      fn_bad  <= 1'b0;
      wr_en   <= 1'b0;
      wr_cfg  <= 1'b0;
      wr_fn   <= '0;
      wr_ofs  <= '0;
      wr_data <= '0;
      err     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      case (st)
        S_IDLE: if (hdr_vld) begin
          en_q <= zone_en;
          st   <= first_zone(zone_en);
        end
        S_LOCAL: if (take) begin
          if (LOCAL_WMASK[w_ofs]) begin
            wr_en <= 1'b1; wr_cfg <= 1'b0; wr_fn <= '0;
            wr_ofs <= w_ofs; wr_data <= w_dat;
          end
          if (!w_cont) st <= first_zone(en_q & 3'b110);
        end
        S_ID: if (take) begin
          if (id_ok) begin
            wr_en <= 1'b1; wr_cfg <= 1'b1; wr_fn <= '1;
            wr_ofs <= id_ofs; wr_data <= w_dat;
          end else begin
            err <= 1'b1;
          end
          if (!w_cont) st <= first_zone(en_q & 3'b100);
        end
        S_FHDR: if (take) begin
          if (!w_cont) begin
            st <= S_DONE;
          end else begin
            st     <= S_FCFG;
            fn_q   <= w_fn;
            fn_bad <= hdr_bad;
            if (hdr_bad) err <= 1'b1;
          end
        end
        S_FCFG: if (take) begin
          if (!fn_bad) begin
            if (ofs_vid) begin
              err <= 1'b1;
            end else begin
              wr_en <= 1'b1; wr_cfg <= 1'b1; wr_fn <= NFN'(1) << fn_q;
              wr_ofs <= w_ofs; wr_data <= w_dat;
            end
          end
          if (!w_cont) st <= S_FHDR;
        end
        default: st <= S_DONE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!wr_en && !word_req && !done)); // R1
  AST_WR_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(take)); // R3
  AST_LOCAL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_cfg) |-> (LOCAL_WMASK[wr_ofs] && wr_fn == '0)); // R4
  AST_ID_BCAST_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cfg && (&wr_fn)) |-> is_vid(wr_ofs)); // R6
  AST_PERFN_NO_VID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cfg && !(&wr_fn)) |-> ($countones(wr_fn) == 1 && !is_vid(wr_ofs))); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !word_req && !wr_en)); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R12
endmodule

// File: tb/tb_cfg_stream_loader.sv
module tb_cfg_stream_loader;
  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] MASK = 128'h0000_0000_0000_0000_0000_00FF_F0F0_FFF7;

  logic clk = 1'b0, rst_n = 1'b0, hdr_vld = 1'b0, word_vld;
  logic [2:0] zone_en = '0;
  logic word_req, wr_en, wr_cfg, done, err;
  logic [15:0] word_data;
  logic [1:0] wr_fn;
  logic [6:0] wr_ofs;
  logic [7:0] wr_data;

  cfg_stream_loader #(.LOCAL_WMASK(MASK)) dut (
    .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .zone_en(zone_en),
    .word_req(word_req), .word_vld(word_vld), .word_data(word_data),
    .wr_en(wr_en), .wr_cfg(wr_cfg), .wr_fn(wr_fn), .wr_ofs(wr_ofs),
    .wr_data(wr_data), .done(done), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] mem [0:255];
  logic [17:0] got [0:255];
  logic [17:0] expw [0:255];
  int ptr = 0, cyc = 0, got_n = 0, exp_n = 0, exp_words = 0, nw = 0;
  int checks = 0, failures = 0;
  logic exp_err, stall = 1'b0;

  assign word_data = mem[ptr[7:0]];
  assign word_vld  = word_req && (!stall || (cyc % 4 != 3));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) ptr <= 0;
    else if (word_req && word_vld) ptr <= ptr + 1;
  end

  always @(negedge clk) if (rst_n && wr_en) begin
    got[got_n[7:0]] <= {wr_cfg, wr_fn, wr_ofs, wr_data};
    got_n <= got_n + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int ex);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, ex);
    end
  endtask

  task automatic put(input logic [15:0] w);
    mem[nw[7:0]] = w; nw++;
  endtask

  task automatic build(input logic [2:0] en, input int seed);
    logic [7:0] d;
    int fns [3];
    int ofl [7];
    nw = 0;
    fns = '{0, 2, 1};
    ofl = '{4, 0, 'h2C, 'h3C, 'h2D, 1, 'h3D};
    if (en[0]) for (int o = 0; o < 128; o++) begin
      d = 8'((o * 3 + seed) & 255);
      put({(o != 127), 7'(o), d});
    end
    if (en[1]) for (int o = 0; o < 6; o++) put({(o != 5), 7'(o), 8'(8'hA0 + o + seed)});
    if (en[2]) begin
      foreach (fns[i]) begin
        put({1'b1, 12'h000, 3'(fns[i])});
        foreach (ofl[k]) put({(k != 6), 7'(ofl[k]), 8'(k * 17 + i + seed)});
      end
      put(16'h0000);
    end
  endtask

  function automatic bit vid(input logic [6:0] o);
    return o == 7'h00 || o == 7'h01 || o == 7'h2C || o == 7'h2D;
  endfunction

  task automatic model(input logic [2:0] en);
    int p;
    logic c, bad;
    logic [15:0] w;
    logic [6:0] o;
    p = 0; exp_n = 0; exp_err = 1'b0;
    if (en[0]) begin
      c = 1'b1;
      while (c) begin
        w = mem[p[7:0]]; p++; o = w[14:8];
        if (MASK[o]) begin expw[exp_n[7:0]] = {1'b0, 2'b00, o, w[7:0]}; exp_n++; end
        c = w[15];
      end
    end
    if (en[1]) begin
      c = 1'b1;
      while (c) begin
        w = mem[p[7:0]]; p++; o = w[14:8];
        if (o < 4) begin
          expw[exp_n[7:0]] = {1'b1, 2'b11, (o[1] ? 7'h2C + 7'(o[0]) : 7'(o[0])), w[7:0]};
          exp_n++;
        end else exp_err = 1'b1;
        c = w[15];
      end
    end
    if (en[2]) begin
      w = mem[p[7:0]]; p++;
      while (w[15]) begin
        bad = (w[2:0] > 1);
        if (bad) exp_err = 1'b1;
        o = (w[2:0] == 0) ? 7'd1 : 7'd2;
        c = 1'b1;
        begin
          logic [1:0] m;
          m = o[1:0];
          while (c) begin
            w = mem[p[7:0]]; p++;
            if (!bad) begin
              if (vid(w[14:8])) exp_err = 1'b1;
              else begin expw[exp_n[7:0]] = {1'b1, m, w[14:8], w[7:0]}; exp_n++; end
            end
            c = w[15];
          end
        end
        w = mem[p[7:0]]; p++;
      end
    end
    exp_words = p;
  endtask

  function automatic string kind(input logic [17:0] e);
    if (!e[17]) return "R4 local write";
    if (e[16:15] == 2'b11) return "R6 id broadcast";
    return "R8 per-function write";
  endfunction

  task automatic run(input logic [2:0] en, input bit stl, input int seed);
    int t, n0;
    stall = stl;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    got_n = 0;
    @(negedge clk);
    chk(!word_req && !wr_en && !done && !err, "R1 reset state",
        {word_req, wr_en, done, err}, 0);
    build(en, seed);
    model(en);
    zone_en = en; hdr_vld = 1'b1;
    @(negedge clk);
    hdr_vld = 1'b0; zone_en = ~en;
    if (en == 3'b000) chk(done && !word_req, "R2 done right after empty header", {done, word_req}, 2);
    else chk(word_req && !done, "R2 request after header", {word_req, done}, 1);
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk(done, "R11 walk finished", done, 1);
    @(negedge clk);
    chk(ptr == exp_words, "R5 words consumed", ptr, exp_words);
    chk(got_n == exp_n, "R4 R10 write count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk(got[i] == expw[i], kind(expw[i]), got[i], expw[i]);
    chk(err == exp_err, "R7 R9 R10 error flag", err, exp_err);
    n0 = got_n;
    hdr_vld = 1'b1; zone_en = 3'b111;
    @(negedge clk);
    hdr_vld = 1'b0;
    repeat (5) @(negedge clk);
    chk(done && !word_req && got_n == n0, "R11 done sticky, header ignored",
        {done, word_req}, 2);
    chk(err == exp_err, "R12 error flag held", err, exp_err);
  endtask

  initial begin
    for (int s = 0; s < 16; s++) begin
      run(3'(s % 8), (s >= 8), s * 5);
      if (cyc > 190000) begin
        failures++; checks++;
        $display("FAIL R11 watchdog actual=%0d expected<190000", cyc);
        break;
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++; checks++;
    $display("FAIL R11 watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule